// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave with Access Recovery Timer

This block sits on the peripheral side of a multiplexed 8-bit address/data bus whose address strobe and data strobe have no phase relationship with the peripheral clock. It takes a register address from the shared bus lines when the address strobe rises, and keeps it for the data phase that follows. Both strobes are resynchronised into the peripheral clock domain and turned into one-cycle internal pulses. On a selected write it issues a one-cycle write enable with the latched address and the captured data. On a selected read it issues a one-cycle read enable and drives the register contents back onto the bus. Every rise of the address strobe is also passed on as a one-cycle pulse, whether or not the device is selected, so that an external interrupt section can advance.

Accesses to this device must be spaced at least four peripheral clocks apart, measured from one data-strobe fall to the next. A selected access that arrives too early is dropped, and a sticky error flag records it. Bus cycles that do not select the device, and interrupt acknowledge cycles, neither start nor disturb the recovery count.

Control flow is a four-state machine. IDLE waits for an address phase. ADDR holds a latched address and waits for the data strobe. READ drives the bus. HOLD waits out a write, an ignored cycle or a rejected cycle. The transitions are as follows. Any synchronised address-strobe rise goes to ADDR from every state, and this has priority over the others. ADDR goes to READ on an accepted read data-strobe fall. ADDR goes to HOLD on any other data-strobe fall. READ and HOLD return to IDLE on a data-strobe rise. IDLE stays in IDLE otherwise.

Top module: `adbus_slave`

## Requirements
- R1: While reset is high and on the first cycle after it, `ad_oe`, `wr_en`, `rd_en`, `as_pulse` and `recov_err` are all 0. Reset is synchronous and active high.
- R2: On the synchronised rise of `as_n`, the block latches `ad_in`, `cs0_n` and `iack_n` as they were when the rise was first sampled. `reg_addr` presents that address until the next address phase.
- R3: A selected write is one where the latched `cs0_n` is 0, the latched `iack_n` is 1, and `cs1_n` is 0 and `rw` is 0 at the fall of `ds_n`. It produces exactly one `wr_en` pulse of one cycle, two to three clocks after `ds_n` falls, with `wr_data` equal to `ad_in` at that fall.
- R4: A selected read (`rw` = 1) produces one `rd_en` pulse of one cycle. From the next cycle `ad_oe` is 1 and `ad_out` equals `rd_data`, until the synchronised rise of `ds_n` returns `ad_oe` to 0.
- R5: `as_pulse` is high for exactly one cycle for each rise of `as_n`, whatever the select and acknowledge inputs are.
- R6: A cycle with latched `cs0_n` = 1 or with `cs1_n` = 1 at the data strobe raises no strobe, does not restart the recovery count and does not set `recov_err`.
- R7: A cycle with latched `iack_n` = 0 raises no `wr_en` or `rd_en` and has no effect on the recovery count or on `recov_err`.
- R8: A selected `ds_n` fall that comes fewer than RECOV_CYCLES (default 4) clocks after the previous accepted one is dropped, with no strobe. A fall that comes 4 or more clocks after it is accepted.
- R9: A dropped access sets `recov_err`. The flag stays set through later accepted accesses and is cleared only by reset.
- R10: The first selected access after reset is accepted whatever its timing, because the recovery count comes out of reset expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| ad_in | input | 8 | Address/data bus, input side |
| ad_out | output | 8 | Address/data bus, output side (read data) |
| ad_oe | output | 1 | Output enable for the bus during a read |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| rw | input | 1 | 1 = read, 0 = write |
| cs0_n | input | 1 | Select qualifier sampled in the address phase, active low |
| cs1_n | input | 1 | Select qualifier for the data phase, active low |
| iack_n | input | 1 | Interrupt acknowledge, sampled in the address phase, active low |
| reg_addr | output | 8 | Latched register address |
| wr_data | output | 8 | Write data captured at the data-strobe fall |
| wr_en | output | 1 | One-cycle register write strobe |
| rd_en | output | 1 | One-cycle register read strobe |
| rd_data | input | 8 | Register read data |
| as_pulse | output | 1 | One-cycle pulse per address-strobe rise |
| recov_err | output | 1 | Sticky recovery-violation flag |

## Verification
A recovery counter that loads or counts wrongly moves the accept boundary. It shows up within one access pair as a dropped access at a spacing of four clocks, or an accepted one at three, and `recov_err` changes along with it. A latch or pipeline stage out of alignment gives a wrong `reg_addr` or `wr_data` at the very next strobe. A state machine that stays in or leaves READ at the wrong time shows in `ad_oe` within three clocks of the data-strobe edges. Exhaustive sweeps over all addresses and over access spacings from three to seven clocks expose each of these on the first access affected.

// File: rtl/adbus_pkg.sv
package adbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_READ = 2'd2,
        ST_HOLD = 2'd3
    } bus_state_t;

    localparam int STB_AS = 0;
    localparam int STB_DS = 1;

endpackage

// File: rtl/adbus_sync.sv
module adbus_sync #(
    parameter int NSTB = 2,
    parameter int PW   = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSTB-1:0] stb_n,
    input  logic [PW-1:0]   pipe_in,
    output logic [NSTB-1:0] rise,
    output logic [NSTB-1:0] fall,
    output logic [PW-1:0]   pipe_out
);

    logic [PW-1:0] p1, p2;

    // Qualifier/data pipeline kept aligned with the strobe's second stage
    always_ff @(posedge clk) begin
        if (rst) begin
            p1 <= '1;
            p2 <= '1;
        end else begin
            p1 <= pipe_in;
            p2 <= p1;
        end
    end

    assign pipe_out = p2;

    for (genvar gi = 0; gi < NSTB; gi++) begin : g_stb
        logic [2:0] sh;

        always_ff @(posedge clk) begin
            if (rst) sh <= 3'b111;
            else     sh <= {sh[1:0], stb_n[gi]};
        end

        assign rise[gi] = sh[1] & ~sh[2];
        assign fall[gi] = ~sh[1] & sh[2];

        // R5
        single_rise_chk: assert property (@(posedge clk) disable iff (rst)
            rise[gi] |=> !rise[gi]);
    end

endmodule

// File: rtl/adbus_recov.sv
module adbus_recov #(
    parameter int RECOV_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(RECOV_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(RECOV_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (start)      cnt <= LOAD;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R8
    recov_load_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> cnt == LOAD);

endmodule

// File: rtl/adbus_slave.sv
module adbus_slave
    import adbus_pkg::*;
#(
    parameter int DW           = 8,
    parameter int RECOV_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    input  logic          as_n,
    input  logic          ds_n,
    input  logic          rw,
    input  logic          cs0_n,
    input  logic          cs1_n,
    input  logic          iack_n,
    output logic [DW-1:0] reg_addr,
    output logic [DW-1:0] wr_data,
    output logic          wr_en,
    output logic          rd_en,
    input  logic [DW-1:0] rd_data,
    output logic          as_pulse,
    output logic          recov_err
);

    localparam int PW = DW + 4;

    logic [1:0]    stb_rise, stb_fall;
    logic [PW-1:0] pipe_q;
    logic [DW-1:0] p_ad;
    logic          p_cs1_n, p_rw, p_cs0_n, p_iack_n;
    logic          as_rise, ds_rise, ds_fall;
    logic          busy, sel, accept, violate;

    bus_state_t    state, state_nx;
    logic [DW-1:0] lat_addr;
    logic          lat_cs0_n, lat_iack_n;

    adbus_sync #(.NSTB(2), .PW(PW)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .stb_n    ({ds_n, as_n}),
        .pipe_in  ({cs1_n, rw, cs0_n, iack_n, ad_in}),
        .rise     (stb_rise),
        .fall     (stb_fall),
        .pipe_out (pipe_q)
    );

    assign {p_cs1_n, p_rw, p_cs0_n, p_iack_n, p_ad} = pipe_q;
    assign as_rise = stb_rise[STB_AS];
    assign ds_rise = stb_rise[STB_DS];
    assign ds_fall = stb_fall[STB_DS];

    adbus_recov #(.RECOV_CYCLES(RECOV_CYCLES)) u_recov (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .busy  (busy)
    );

    // Address phase latch
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_addr   <= '0;
            lat_cs0_n  <= 1'b1;
            lat_iack_n <= 1'b1;
        end else if (as_rise) begin
            lat_addr   <= p_ad;
            lat_cs0_n  <= p_cs0_n;
            lat_iack_n <= p_iack_n;
        end
    end

    assign sel     = ds_fall && (state == ST_ADDR) && !lat_cs0_n && !p_cs1_n && lat_iack_n;
    assign accept  = sel && !busy;
    assign violate = sel && busy;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (as_rise) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_ADDR: if (ds_fall) state_nx = (accept && p_rw) ? ST_READ : ST_HOLD;
                ST_READ: if (ds_rise) state_nx = ST_IDLE;
                ST_HOLD: if (ds_rise) state_nx = ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Sticky recovery violation
    always_ff @(posedge clk) begin
        if (rst)          recov_err <= 1'b0;
        else if (violate) recov_err <= 1'b1;
    end

    // Outputs
    always_comb begin
        reg_addr = lat_addr;
        wr_data  = p_ad;
        wr_en    = accept && !p_rw;
        rd_en    = accept && p_rw;
        ad_oe    = (state == ST_READ);
        ad_out   = rd_data;
        as_pulse = as_rise;
    end

    // R3
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R4
    oe_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ad_oe) |-> $past(rd_en));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        recov_err |=> recov_err);

endmodule

// File: tb/adbus_slave_test.sv
module adbus_slave_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic       as_n = 1'b1, ds_n = 1'b1, rw = 1'b0;
    logic       cs0_n = 1'b1, cs1_n = 1'b1, iack_n = 1'b1;
    logic [7:0] reg_addr, wr_data, rd_data;
    logic       wr_en, rd_en, as_pulse, recov_err;

    int checks = 0, failures = 0;
    int wr_cnt = 0, rd_cnt = 0, as_cnt = 0;
    logic [7:0] last_waddr = 0, last_wdata = 0, last_raddr = 0;
    logic oe_s, oe_off;
    logic [7:0] out_s;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rd_data = reg_addr ^ 8'h5A;

    adbus_slave uut (
        .clk(clk), .rst(rst), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .as_n(as_n), .ds_n(ds_n), .rw(rw), .cs0_n(cs0_n), .cs1_n(cs1_n),
        .iack_n(iack_n), .reg_addr(reg_addr), .wr_data(wr_data), .wr_en(wr_en),
        .rd_en(rd_en), .rd_data(rd_data), .as_pulse(as_pulse), .recov_err(recov_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin wr_cnt++; last_waddr = reg_addr; last_wdata = wr_data; end
            if (rd_en) begin rd_cnt++; last_raddr = reg_addr; end
            if (as_pulse) as_cnt++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic access(input logic [7:0] a, input logic [7:0] d, input bit rd,
                          input bit c0n, input bit c1n, input bit ikn,
                          input int lo, input int idle);
        as_n = 1'b0; ad_in = a; cs0_n = c0n; iack_n = ikn;
        @(negedge clk);
        as_n = 1'b1;
        @(negedge clk);
        ad_in = d; rw = rd; cs1_n = c1n; ds_n = 1'b0;
        for (int k = 0; k < lo; k++) begin
            @(negedge clk);
            if (k == 3) begin oe_s = ad_oe; out_s = ad_out; end
        end
        ds_n = 1'b1; cs1_n = 1'b1;
        for (int k = 0; k < idle; k++) begin
            @(negedge clk);
            if (k == 2) oe_off = ad_oe;
        end
    endtask

    task automatic settle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        settle(3);
        chk("R1 ad_oe", ad_oe, 0);
        chk("R1 wr_en", wr_en, 0);
        chk("R1 rd_en", rd_en, 0);
        chk("R1 as_pulse", as_pulse, 0);
        chk("R9 recov_err cleared", recov_err, 0);
        @(negedge clk);
        rst = 1'b0;
        settle(1);
        chk("R1 post-reset ad_oe", ad_oe, 0);
        chk("R1 post-reset wr_en", wr_en, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int w0, r0, a0;
        do_reset();
        @(negedge clk);

        // R10: first access right after reset accepted
        access(8'h3C, 8'hA5, 0, 0, 0, 1, 2, 4);
        settle(1);
        chk("R10 first write accepted", wr_cnt, 1);
        chk("R3 first wdata", last_wdata, 8'hA5);
        chk("R2 first waddr", last_waddr, 8'h3C);
        @(negedge clk);

        // R2/R3: exhaustive address sweep of writes
        for (int a = 0; a < 256; a++) begin
            logic [7:0] dv;
            w0 = wr_cnt;
            dv = 8'((a * 7 + 3) & 8'hFF);
            access(8'(a), dv, 0, 0, 0, 1, 2, 4);
            #1;
            chk("R3 write count", wr_cnt - w0, 1);
            chk("R2 write addr", last_waddr, a);
            chk("R3 write data", last_wdata, dv);
        end

        // R4: exhaustive read sweep
        for (int a = 0; a < 256; a++) begin
            w0 = wr_cnt; r0 = rd_cnt;
            access(8'(a), 8'hFF, 1, 0, 0, 1, 6, 4);
            #1;
            chk("R4 read count", rd_cnt - r0, 1);
            chk("R4 no write on read", wr_cnt - w0, 0);
            chk("R2 read addr", last_raddr, a);
            chk("R4 oe during DS low", oe_s, 1);
            chk("R4 ad_out value", out_s, a ^ 8'h5A);
            chk("R4 oe after DS rise", oe_off, 0);
        end

        // R5: one pulse per AS cycle so far
        chk("R5 as pulses", as_cnt, 1 + 256 + 256);

        // R6: cs0 inactive between two selected writes spaced 6 apart
        w0 = wr_cnt; a0 = as_cnt;
        access(8'h11, 8'h22, 0, 0, 0, 1, 1, 0);
        access(8'h12, 8'h23, 0, 1, 0, 1, 1, 0);
        access(8'h13, 8'h24, 0, 0, 0, 1, 1, 4);
        settle(1);
        chk("R6 cs0 ignored count", wr_cnt - w0, 2);
        chk("R6 cs0 last data", last_wdata, 8'h24);
        chk("R6 cs0 no error", recov_err, 0);
        chk("R5 unselected as pulses", as_cnt - a0, 3);

        // R6: cs1 inactive
        w0 = wr_cnt; r0 = rd_cnt;
        access(8'h21, 8'h31, 0, 0, 0, 1, 1, 0);
        access(8'h22, 8'h32, 1, 0, 1, 1, 1, 0);
        access(8'h23, 8'h33, 0, 0, 0, 1, 1, 4);
        settle(1);
        chk("R6 cs1 ignored count", wr_cnt - w0, 2);
        chk("R6 cs1 no read", rd_cnt - r0, 0);
        chk("R6 cs1 no error", recov_err, 0);

        // R7: interrupt acknowledge cycle
        w0 = wr_cnt; r0 = rd_cnt; a0 = as_cnt;
        access(8'h41, 8'h51, 0, 0, 0, 1, 1, 0);
        access(8'h42, 8'h52, 1, 0, 0, 0, 1, 0);
        access(8'h43, 8'h53, 0, 0, 0, 1, 1, 4);
        settle(1);
        chk("R7 iack write count", wr_cnt - w0, 2);
        chk("R7 iack no read", rd_cnt - r0, 0);
        chk("R7 iack no error", recov_err, 0);
        chk("R5 iack as pulses", as_cnt - a0, 3);

        // R8: spacing sweep, accepted at 4 and above
        for (int sep = 7; sep >= 4; sep--) begin
            w0 = wr_cnt;
            access(8'h60, 8'h70, 0, 0, 0, 1, 1, sep - 3);
            access(8'h61, 8'h71, 0, 0, 0, 1, 1, 6);
            settle(1);
            chk("R8 spacing accepted", wr_cnt - w0, 2);
            chk("R8 spaced data", last_wdata, 8'h71);
            chk("R9 no error when spaced", recov_err, 0);
        end

        // R8/R9: spacing 3 dropped
        w0 = wr_cnt;
        access(8'h80, 8'h90, 0, 0, 0, 1, 1, 0);
        access(8'h81, 8'h91, 0, 0, 0, 1, 1, 6);
        settle(1);
        chk("R8 early access dropped", wr_cnt - w0, 1);
        chk("R8 dropped data kept", last_wdata, 8'h90);
        chk("R9 error set", recov_err, 1);

        // R9: sticky across later good access
        w0 = wr_cnt;
        access(8'h82, 8'h92, 0, 0, 0, 1, 2, 6);
        settle(1);
        chk("R9 later access accepted", wr_cnt - w0, 1);
        chk("R9 error sticky", recov_err, 1);

        do_reset();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule